// File: doc/BRIEF.md
# Chainable Dual Byte Timer with High-Byte Snapshot

The block holds two byte-wide up-counters that a simple register bus reads and writes. A single mode input picks between two layouts. In one, the counters run as separate 8-bit timers. In the other, they chain into one 16-bit timer. Each counter advances on enable strobes taken from one of three sources: a prescaled slow strobe, a fast strobe, or an external pin. The pin is synchronized and edge-detected first. Any bus write to a counter byte zeroes it, and the data on the bus is thrown away.

In the chained layout, the upper byte advances only when the lower byte rolls over. Software reads the lower byte first. That read copies the upper byte into a holding register, and a later read of the upper byte returns the copy. The two halves therefore form one consistent 16-bit sample, even while counting continues. Each counter drives a single-cycle overflow pulse when it wraps to zero.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counter bytes read 00H and both overflow outputs are low. A counter that is running with its source strobe high on a clock edge increases by one on that edge.
- R2: A write (`wr_en` high) to address 0 clears the low byte and a write to address 1 clears the high byte. This holds in 8-bit mode and for any `wdata`. The other byte is left unchanged. If a clear and a count strobe fall in the same cycle, the clear wins.
- R3: With `mode16` high, a write to either address clears both bytes, giving 0000H.
- R4: With `mode16` high, the high byte increments only on a low-byte strobe that takes the low byte from FFH to 00H. In this mode the low byte's run bit and source drive the whole 16-bit count.
- R5: With `mode16` high, a read (`rd_en` high) of address 0 returns the live low byte and copies the high byte into a holding register. A read of address 1 returns that copy, not the live high byte.
- R6: With `mode16` low, the two bytes count independently, each from its own run bit and source. A read of address 1 returns the live high byte.
- R7: While a counter's run bit is low, its count holds whatever strobes arrive.
- R8: Source select encoding is 0 = slow strobe `slow_tick`, 1 = fast strobe `fast_tick`, 2 = external pin edge, 3 = no source. A strobe on an unselected source has no effect.
- R9: The external pin passes through a two-flop synchronizer and a rising-edge detector. One pin rise gives exactly one count. A rise set up before clock edge k appears in the count after edge k+2.
- R10: A counter that wraps to zero raises its overflow output for exactly one cycle, the cycle after the wrapping edge. In 16-bit mode, `ovf_hi` marks the wrap from FFFFH to 0000H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode16 | input | 1 | 1 = chain the bytes into one 16-bit timer |
| run_lo | input | 1 | Run bit of the low counter |
| run_hi | input | 1 | Run bit of the high counter (8-bit mode only) |
| src_lo | input | 2 | Strobe source of the low counter |
| src_hi | input | 2 | Strobe source of the high counter (8-bit mode only) |
| slow_tick | input | 1 | Prescaled slow-clock enable strobe |
| fast_tick | input | 1 | Fast-clock enable strobe |
| ext_pin | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Bus write strobe (clears the addressed byte) |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 1 | Byte select: 0 = low, 1 = high |
| wdata | input | 8 | Write data, discarded |
| rdata | output | 8 | Read data (combinational) |
| ovf_lo | output | 1 | Low counter overflow pulse |
| ovf_hi | output | 1 | High counter (or 16-bit) overflow pulse |

## Verification
The assertions assume that `mode16` does not change while a low-byte read is in flight. They also assume the strobe inputs are synchronous single-clock levels, and that only `ext_pin` may change at any time. The stimulus changes every input only at the falling clock edge. It changes the mode only between test steps, after the counters have been cleared. The external pin is held for several cycles at each level, so every rise passes through both synchronizer flops.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_OFF  = 2'd3
  } tick_src_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R9: a detected edge lasts one cycle only
  assert_single_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  tick_src_e sel,
  input  logic      slow_tick,
  input  logic      fast_tick,
  input  logic      ext_rise,
  output logic      tick
);
  always_comb begin
    unique case (sel)
      SRC_SLOW: tick = slow_tick;
      SRC_FAST: tick = fast_tick;
      SRC_EXT:  tick = ext_rise;
      default:  tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_byte_cnt.sv
module tmr_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      ovf_d = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));
  assert_ovf_wraps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> cnt_q == '0);
  assert_ovf_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode16,
  input  logic         run_lo,
  input  logic         run_hi,
  input  logic [1:0]   src_lo,
  input  logic [1:0]   src_hi,
  input  logic         slow_tick,
  input  logic         fast_tick,
  input  logic         ext_pin,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         ovf_lo,
  output logic         ovf_hi
);
  localparam logic [W-1:0] BYTE_MAX = {W{1'b1}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic ext_rise;
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(ext_pin), .rise(ext_rise)
  );

  logic tick_lo, tick_hi;
  tmr_tick_sel u_sel_lo (
    .sel(tick_src_e'(src_lo)), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .ext_rise(ext_rise), .tick(tick_lo)
  );
  tmr_tick_sel u_sel_hi (
    .sel(tick_src_e'(src_hi)), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .ext_rise(ext_rise), .tick(tick_hi)
  );

  logic [W-1:0] cnt_lo, cnt_hi;
  logic         inc_lo, inc_hi, clr_lo, clr_hi;

  always_comb begin
    inc_lo = run_lo & tick_lo;
    inc_hi = mode16 ? (inc_lo & (cnt_lo == BYTE_MAX)) : (run_hi & tick_hi);
    clr_lo = wr_en & (mode16 | ~addr);
    clr_hi = wr_en & (mode16 | addr);
  end

  tmr_byte_cnt #(.W(W)) u_cnt_lo (
    .clk(clk), .rst_n(rst_int_n), .clr(clr_lo), .inc(inc_lo),
    .cnt(cnt_lo), .ovf(ovf_lo)
  );
  tmr_byte_cnt #(.W(W)) u_cnt_hi (
    .clk(clk), .rst_n(rst_int_n), .clr(clr_hi), .inc(inc_hi),
    .cnt(cnt_hi), .ovf(ovf_hi)
  );

  // high-byte snapshot taken on a low-byte read in chained mode
  logic [W-1:0] hold_q, hold_d;
  logic         snap;
  always_comb begin
    snap   = rd_en & ~addr & mode16;
    hold_d = snap ? cnt_hi : hold_q;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hold_q <= '0;
    else            hold_q <= hold_d;
  end

  always_comb begin
    if (!addr)       rdata = cnt_lo;
    else if (mode16) rdata = hold_q;
    else             rdata = cnt_hi;
  end

  assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && !addr && mode16) |=> hold_q == $past(cnt_hi));
  assert_carry_only_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(mode16) && !$past(wr_en) && cnt_hi != $past(cnt_hi))
      |-> ($past(cnt_lo) == BYTE_MAX && cnt_lo == '0));
  assert_chain_clear_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && mode16) |=> (cnt_lo == '0 && cnt_hi == '0));
  assert_data_ignored_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !addr && wdata != '0) |=> cnt_lo == '0);
endmodule

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
  logic clk = 1'b0;
  logic rst_n;
  logic mode16, run_lo, run_hi, slow_tick, fast_tick, ext_pin;
  logic [1:0] src_lo, src_hi;
  logic wr_en, rd_en, addr;
  logic [7:0] wdata, rdata;
  logic ovf_lo, ovf_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_pair uut (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .run_lo(run_lo), .run_hi(run_hi),
    .src_lo(src_lo), .src_hi(src_hi), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .ext_pin(ext_pin), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
  );

  // mode16, fast strobes, expected low byte, expected high byte
  typedef struct packed {
    logic        m16;
    logic [15:0] n;
    logic [7:0]  lo;
    logic [7:0]  hi;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd5,   8'h05, 8'h00},
    '{1'b0, 16'd255, 8'hFF, 8'h00},
    '{1'b0, 16'd256, 8'h00, 8'h00},
    '{1'b1, 16'd256, 8'h00, 8'h01},
    '{1'b1, 16'd300, 8'h2C, 8'h01},
    '{1'b1, 16'd515, 8'h03, 8'h02}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fast_n(input int n);
    if (n > 0) begin
      @(negedge clk); fast_tick = 1'b1;
      repeat (n) @(negedge clk);
      fast_tick = 1'b0;
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; mode16 = 0; run_lo = 0; run_hi = 0; src_lo = 2'd1; src_hi = 2'd1;
    slow_tick = 0; fast_tick = 0; ext_pin = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_rd(1'b0, v); check(v, 8'h00, "R1 reset low");
    bus_rd(1'b1, v); check(v, 8'h00, "R1 reset high");
    check({7'd0, ovf_lo | ovf_hi}, 8'h00, "R1 reset ovf");

    // vector table: R1 R4 R6 R7 (high stays put in 8-bit mode with run_hi low)
    run_lo = 1'b1;
    for (int i = 0; i < NV; i++) begin
      mode16 = VECS[i].m16;
      bus_wr(1'b0, 8'hA5); bus_wr(1'b1, 8'h5A);
      fast_n(int'(VECS[i].n));
      bus_rd(1'b0, v); check(v, VECS[i].lo, "R1/R4 table low");
      bus_rd(1'b1, v); check(v, VECS[i].hi, "R4/R7 table high");
    end

    // R6 independent bytes, live high read; R2 per-byte clear with data
    mode16 = 0; run_hi = 1;
    bus_wr(1'b0, 8'h00); bus_wr(1'b1, 8'h00);
    fast_n(7);
    run_lo = 0; fast_n(3); run_lo = 1;
    bus_rd(1'b1, v); check(v, 8'h0A, "R6 live high");
    bus_rd(1'b0, v); check(v, 8'h07, "R7 low held while stopped");
    bus_wr(1'b0, 8'hFF);
    bus_rd(1'b0, v); check(v, 8'h00, "R2 low cleared");
    bus_rd(1'b1, v); check(v, 8'h0A, "R2 high untouched");
    // clear wins over strobe in the same cycle
    @(negedge clk); fast_tick = 1; wr_en = 1; addr = 1; wdata = 8'h33;
    @(negedge clk); fast_tick = 0; wr_en = 0;
    bus_rd(1'b1, v); check(v, 8'h00, "R2 clear beats count");
    run_hi = 0;

    // R5 snapshot coherency in 16-bit mode
    mode16 = 1;
    bus_wr(1'b0, 8'h00);
    fast_n(261);
    bus_rd(1'b0, v); check(v, 8'h05, "R5 low read");
    fast_n(256);
    bus_rd(1'b1, v); check(v, 8'h01, "R5 high from snapshot");
    bus_rd(1'b0, v); check(v, 8'h05, "R5 low reread");
    bus_rd(1'b1, v); check(v, 8'h02, "R5 snapshot refreshed");

    // R3 write to the high address clears the full 16-bit count
    bus_wr(1'b1, 8'h77);
    bus_rd(1'b0, v); check(v, 8'h00, "R3 low cleared");
    bus_rd(1'b1, v); check(v, 8'h00, "R3 high cleared");

    // R10 16-bit wrap and one-cycle pulse
    fast_n(65535);
    bus_rd(1'b0, v); check(v, 8'hFF, "R10 low at max");
    bus_rd(1'b1, v); check(v, 8'hFF, "R10 high at max");
    @(negedge clk); fast_tick = 1;
    @(negedge clk); fast_tick = 0;
    check({7'd0, ovf_hi}, 8'h01, "R10 16-bit ovf high");
    check({7'd0, ovf_lo}, 8'h01, "R10 low ovf with carry");
    @(negedge clk);
    check({7'd0, ovf_hi}, 8'h00, "R10 ovf one cycle");

    // R8 source selection: slow source ignores fast strobes
    mode16 = 0; src_lo = 2'd0;
    bus_wr(1'b0, 8'h00);
    fast_n(4);
    bus_rd(1'b0, v); check(v, 8'h00, "R8 fast ignored on slow");
    @(negedge clk); slow_tick = 1;
    repeat (3) @(negedge clk); slow_tick = 0;
    bus_rd(1'b0, v); check(v, 8'h03, "R8 slow counts");
    src_lo = 2'd3;
    @(negedge clk); slow_tick = 1; fast_tick = 1;
    repeat (3) @(negedge clk); slow_tick = 0; fast_tick = 0;
    bus_rd(1'b0, v); check(v, 8'h03, "R8 off source");

    // R9 external pin: one count per rise, three-edge latency
    src_lo = 2'd2;
    bus_wr(1'b0, 8'h00);
    @(negedge clk); ext_pin = 1;
    @(negedge clk); @(negedge clk);
    check(uut.rdata, 8'h00, "R9 not yet counted");
    @(negedge clk);
    check(rdata, 8'h01, "R9 counted after third edge");
    repeat (5) @(negedge clk);
    check(rdata, 8'h01, "R9 one count per rise");
    ext_pin = 0; repeat (4) @(negedge clk);
    ext_pin = 1; repeat (6) @(negedge clk);
    check(rdata, 8'h02, "R9 second rise");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule